// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This block settles read-after-write conflicts in an in-order pipeline with five stages: fetch, decode, execute, buffer/data and write-back. Each cycle it compares the three source register numbers of the instruction waiting in decode against the destination numbers of the older instructions now in execute, buffer and write-back. For each operand it picks the place the execute stage should take that operand from on the next cycle. The choices are the operand latch filled from the register file, one of three result registers further down the pipeline, or the fetch-relative program counter.

When a value cannot be forwarded in time, the unit holds fetch and decode and places a bubble into execute. This happens when the producer is a load still in execute, or when a multi-register load has not finished with its highest listed register. The instruction in decode keeps its place and is checked again on the next cycle. When no dependence needs a stall, the unit never stalls, so the pipeline retires one instruction per cycle.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After reset release, with no valid decode instruction, `hold_fetch`, `hold_decode` and `insert_bubble` are 0 and every field of `ex_fwd_sel` is 0.
- R2: Operand i of `dec_src` sits at bits [4i+3:4i], and its select sits in `ex_fwd_sel` at bits [3i+2:3i] one cycle later. The select is 1 (execute/buffer result register) when the execute stage writes the same register.
- R3: When the nearest writer of the source is the buffer stage, the select is 2 (buffer/write-back result register).
- R4: When the nearest writer of the source is the write-back stage, the select is 3 (retired-result register). All three operands are handled independently.
- R5: When several stages write the same source, the youngest one wins: execute before buffer before write-back.
- R6: A source that matches a load in execute raises the hold and bubble outputs for exactly one cycle. When the load has moved to buffer, the same source selects 2 with no stall.
- R7: A load in execute whose destination no valid source uses causes no stall.
- R8: Source register 15 always selects 4 (fetch-relative PC) and never causes a stall, even when an older stage writes or loads register 15.
- R9: While `lm_busy` is 1, a valid source equal to `lm_top_rd` stalls. The stall continues for one more cycle after `lm_busy` falls, using the register number captured while busy. A source naming any other register does not stall.
- R10: Sources whose `dec_use` bit is 0, stages whose write enable is 0, and a decode slot with `dec_valid` 0 cause no match and no stall. In each of these cases the select is 0.
- R11: In a stall cycle, the selects written for execute on the next cycle are all 0 (bubble), and `hold_fetch` equals `hold_decode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_src | input | 12 | Three source register numbers, operand i at [4i+3:4i] |
| dec_use | input | 3 | Operand i is actually read |
| ex_rd | input | 4 | Destination of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| buf_rd | input | 4 | Destination of the buffer-stage instruction |
| buf_wen | input | 1 | Buffer-stage instruction writes a register |
| wb_rd | input | 4 | Destination of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| lm_busy | input | 1 | Multi-register load sequencer still transferring |
| lm_top_rd | input | 4 | Highest register in the multi-register load list |
| hold_fetch | output | 1 | Freeze the fetch stage |
| hold_decode | output | 1 | Freeze the decode stage |
| insert_bubble | output | 1 | Send an empty slot into execute |
| ex_fwd_sel | output | 9 | Registered operand selects for execute, 3 bits each |

## Verification
The hardest situation to reach is the stall cycle that follows a multi-register load. By then `lm_busy` has already dropped, and the register number on `lm_top_rd` may have changed. The stimulus keeps `lm_busy` high for two cycles with a consumer of the top register in decode. It then lowers `lm_busy` and sets `lm_top_rd` to an unrelated value in the same cycle, so only the captured register number can produce the extra stall. One cycle later it checks that the stall has ended. The load-use case is driven the same way across two cycles: the load moves from execute into buffer, and the bench checks that the stall is followed by a select of 2.

// File: rtl/fih_pkg.sv
package fih_pkg;
  // Where execute should take each operand from
  typedef enum logic [2:0] {
    FW_RF  = 3'd0,  // operand latch filled from the register file
    FW_EXB = 3'd1,  // execute/buffer result register
    FW_BWB = 3'd2,  // buffer/write-back result register
    FW_RET = 3'd3,  // retired-result register
    FW_PC  = 3'd4   // fetch-relative program counter
  } fwd_src_e;

  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/operand_match.sv
module operand_match
  import fih_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned PC_IDX = 15
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_i,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] buf_rd,
  input  logic             buf_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output fwd_src_e         sel,
  output logic             load_hit
);
  localparam logic [REG_W-1:0] PC_NUM = REG_W'(PC_IDX);

  logic is_pc;
  logic hit_ex, hit_buf, hit_wb;

  assign is_pc   = (src == PC_NUM);
  assign hit_ex  = use_i && !is_pc && ex_wen  && (ex_rd  == src);
  assign hit_buf = use_i && !is_pc && buf_wen && (buf_rd == src);
  assign hit_wb  = use_i && !is_pc && wb_wen  && (wb_rd  == src);

  // Youngest producer first
  always_comb begin
    sel      = FW_RF;
    load_hit = 1'b0;
    if (use_i && is_pc) begin
      sel = FW_PC;
    end else if (hit_ex) begin
      sel      = FW_EXB;
      load_hit = ex_load;
    end else if (hit_buf) begin
      sel = FW_BWB;
    end else if (hit_wb) begin
      sel = FW_RET;
    end
  end
endmodule

// File: rtl/lm_tail_tracker.sv
module lm_tail_tracker #(
  parameter int unsigned REG_W = 4,
  parameter int unsigned TAIL  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lm_busy,
  input  logic [REG_W-1:0] lm_top_rd,
  output logic             guard_live,
  output logic [REG_W-1:0] guard_rd
);
  localparam int unsigned CNT_W = (TAIL > 1) ? $clog2(TAIL) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'((TAIL > 0) ? (TAIL - 1) : 0);
  localparam logic HAS_TAIL = (TAIL > 0);

  logic             busy_q, busy_n;
  logic [REG_W-1:0] top_q, top_n;
  logic             top_en;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             fall;

  assign fall = busy_q && !lm_busy;

  // Next-state logic
  always_comb begin
    busy_n = lm_busy;
    top_en = lm_busy;
    top_n  = lm_top_rd;
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (fall && HAS_TAIL) begin
      cnt_en = 1'b1;
      cnt_n  = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      top_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (top_en) top_q <= top_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign guard_live = lm_busy || (fall && HAS_TAIL) || (cnt_q != '0);
  assign guard_rd   = lm_busy ? lm_top_rd : top_q;
endmodule

// File: rtl/sel_stage.sv
module sel_stage
  import fih_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bubble,
  input  logic [NUM_SRC*SEL_W-1:0] sel_in,
  output logic [NUM_SRC*SEL_W-1:0] sel_q
);
  logic [NUM_SRC*SEL_W-1:0] sel_n;
  logic                     adv_en;

  // Execute is refilled every cycle: a real instruction or a bubble
  always_comb begin
    adv_en = 1'b1;
    sel_n  = bubble ? '0 : sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (adv_en) begin
      sel_q <= sel_n;
    end
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fih_pkg::*;
#(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned LM_TAIL = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [NUM_SRC*REG_W-1:0] dec_src,
  input  logic [NUM_SRC-1:0]       dec_use,
  input  logic [REG_W-1:0]         ex_rd,
  input  logic                     ex_wen,
  input  logic                     ex_load,
  input  logic [REG_W-1:0]         buf_rd,
  input  logic                     buf_wen,
  input  logic [REG_W-1:0]         wb_rd,
  input  logic                     wb_wen,
  input  logic                     lm_busy,
  input  logic [REG_W-1:0]         lm_top_rd,
  output logic                     hold_fetch,
  output logic                     hold_decode,
  output logic                     insert_bubble,
  output logic [NUM_SRC*SEL_W-1:0] ex_fwd_sel
);
  localparam logic [REG_W-1:0] PC_NUM = REG_W'(PC_IDX);

  logic [NUM_SRC*SEL_W-1:0] sel_raw;
  logic [NUM_SRC-1:0]       ld_hit;
  logic [NUM_SRC-1:0]       lm_hit;
  logic                     lm_guard_live;
  logic [REG_W-1:0]         lm_guard_rd;
  logic                     stall;

  lm_tail_tracker #(.REG_W(REG_W), .TAIL(LM_TAIL)) u_lm (
    .clk        (clk),
    .rst_n      (rst_n),
    .lm_busy    (lm_busy),
    .lm_top_rd  (lm_top_rd),
    .guard_live (lm_guard_live),
    .guard_rd   (lm_guard_rd)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    logic [REG_W-1:0] src_g;
    fwd_src_e         sel_g;
    assign src_g = dec_src[g*REG_W +: REG_W];

    operand_match #(.REG_W(REG_W), .PC_IDX(PC_IDX)) u_match (
      .src      (src_g),
      .use_i    (dec_use[g]),
      .ex_rd    (ex_rd),
      .ex_wen   (ex_wen),
      .ex_load  (ex_load),
      .buf_rd   (buf_rd),
      .buf_wen  (buf_wen),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_wen),
      .sel      (sel_g),
      .load_hit (ld_hit[g])
    );

    assign sel_raw[g*SEL_W +: SEL_W] = sel_g;
    assign lm_hit[g] = dec_use[g] && lm_guard_live &&
                       (src_g == lm_guard_rd) && (src_g != PC_NUM);
  end

  assign stall = dec_valid && ((|ld_hit) || (|lm_hit));

  assign hold_fetch    = stall;
  assign hold_decode   = stall;
  assign insert_bubble = stall;

  sel_stage #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .bubble (stall || !dec_valid),
    .sel_in (sel_raw),
    .sel_q  (ex_fwd_sel)
  );
endmodule

// File: rtl/fih_checker.sv
module fih_checker #(
  parameter int unsigned REG_W   = 4,
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned PC_IDX  = 15
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_valid,
  input logic [NUM_SRC*REG_W-1:0] dec_src,
  input logic [NUM_SRC-1:0]       dec_use,
  input logic [REG_W-1:0]         ex_rd,
  input logic                     ex_wen,
  input logic                     ex_load,
  input logic                     guard_live,
  input logic                     hold_fetch,
  input logic                     hold_decode,
  input logic                     insert_bubble,
  input logic [NUM_SRC*3-1:0]     ex_fwd_sel
);
  localparam logic [REG_W-1:0] PC_NUM = REG_W'(PC_IDX);
  logic [REG_W-1:0] s0;
  assign s0 = dec_src[REG_W-1:0];

  a_r11_bubble_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    hold_decode |=> (ex_fwd_sel == '0));

  a_r8_pc_select: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use[0] && s0 == PC_NUM && !hold_decode) |=> (ex_fwd_sel[2:0] == 3'd4));

  a_r2_exec_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use[0] && s0 != PC_NUM && ex_wen && !ex_load && ex_rd == s0 && !hold_decode)
      |=> (ex_fwd_sel[2:0] == 3'd1));

  a_r6_load_use_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use[0] && s0 != PC_NUM && ex_wen && ex_load && ex_rd == s0)
      |-> (hold_decode && hold_fetch && insert_bubble));

  a_r7_free_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_load && !guard_live) |-> !hold_decode);
endmodule

bind fwd_interlock_unit fih_checker #(
  .REG_W(REG_W), .NUM_SRC(NUM_SRC), .PC_IDX(PC_IDX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .dec_src       (dec_src),
  .dec_use       (dec_use),
  .ex_rd         (ex_rd),
  .ex_wen        (ex_wen),
  .ex_load       (ex_load),
  .guard_live    (lm_guard_live),
  .hold_fetch    (hold_fetch),
  .hold_decode   (hold_decode),
  .insert_bubble (insert_bubble),
  .ex_fwd_sel    (ex_fwd_sel)
);

// File: tb/sim_fwd_interlock_unit.sv
`timescale 1ns/1ps
module sim_fwd_interlock_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid;
  logic [11:0] dec_src;
  logic [2:0]  dec_use;
  logic [3:0]  ex_rd, buf_rd, wb_rd, lm_top_rd;
  logic        ex_wen, ex_load, buf_wen, wb_wen, lm_busy;
  logic        hold_fetch, hold_decode, insert_bubble;
  logic [8:0]  ex_fwd_sel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fwd_interlock_unit u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
    .dec_use(dec_use), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .buf_rd(buf_rd), .buf_wen(buf_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .lm_busy(lm_busy), .lm_top_rd(lm_top_rd), .hold_fetch(hold_fetch),
    .hold_decode(hold_decode), .insert_bubble(insert_bubble),
    .ex_fwd_sel(ex_fwd_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sel_of(input int i);
    return int'(ex_fwd_sel[3*i +: 3]);
  endfunction

  task automatic idle();
    dec_valid = 1'b0; dec_src = '0; dec_use = '0;
    ex_rd = '0; ex_wen = 1'b0; ex_load = 1'b0;
    buf_rd = '0; buf_wen = 1'b0; wb_rd = '0; wb_wen = 1'b0;
    lm_busy = 1'b0; lm_top_rd = '0;
  endtask

  task automatic set_dec(input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] c, input logic [2:0] u);
    dec_valid = 1'b1;
    dec_src   = {c, b, a};
    dec_use   = u;
  endtask

  // Drive after the falling edge, check stall then registered select
  task automatic settle();
    #1;
  endtask

  task automatic to_next_cycle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); settle();
    chk("R1 hold", int'(hold_decode), 0);
    chk("R1 bubble", int'(insert_bubble), 0);
    to_next_cycle();
    chk("R1 sel", int'(ex_fwd_sel), 0);
  endtask

  task automatic t_three_sources();
    @(negedge clk); idle();
    set_dec(4'd3, 4'd4, 4'd5, 3'b111);
    ex_rd = 4'd3; ex_wen = 1'b1;
    buf_rd = 4'd4; buf_wen = 1'b1;
    wb_rd = 4'd5; wb_wen = 1'b1;
    settle();
    chk("R2 no stall", int'(hold_decode), 0);
    to_next_cycle();
    chk("R2 op0 exec", sel_of(0), 1);
    chk("R3 op1 buffer", sel_of(1), 2);
    chk("R4 op2 retire", sel_of(2), 3);
  endtask

  task automatic t_priority();
    @(negedge clk); idle();
    set_dec(4'd6, 4'd6, 4'd1, 3'b011);
    ex_rd = 4'd6; ex_wen = 1'b1; buf_rd = 4'd6; buf_wen = 1'b1;
    wb_rd = 4'd6; wb_wen = 1'b1;
    settle(); to_next_cycle();
    chk("R5 exec wins", sel_of(0), 1);
    @(negedge clk); ex_wen = 1'b0; settle(); to_next_cycle();
    chk("R5 buffer beats writeback", sel_of(1), 2);
    chk("R10 unused operand", sel_of(2), 0);
  endtask

  task automatic t_load_use();
    @(negedge clk); idle();
    set_dec(4'd7, 4'd2, 4'd2, 3'b001);
    ex_rd = 4'd7; ex_wen = 1'b1; ex_load = 1'b1;
    settle();
    chk("R6 load-use hold", int'(hold_decode), 1);
    chk("R11 fetch held too", int'(hold_fetch), 1);
    chk("R6 bubble", int'(insert_bubble), 1);
    to_next_cycle();
    chk("R11 bubble selects", int'(ex_fwd_sel), 0);
    @(negedge clk);
    ex_wen = 1'b0; ex_load = 1'b0; ex_rd = '0;
    buf_rd = 4'd7; buf_wen = 1'b1;
    settle();
    chk("R6 single interlock", int'(hold_decode), 0);
    to_next_cycle();
    chk("R6 from memory stage", sel_of(0), 2);
  endtask

  task automatic t_load_no_use();
    @(negedge clk); idle();
    set_dec(4'd8, 4'd9, 4'd10, 3'b111);
    ex_rd = 4'd7; ex_wen = 1'b1; ex_load = 1'b1;
    settle();
    chk("R7 no stall", int'(hold_decode), 0);
    @(negedge clk); dec_use = 3'b000; dec_src = {4'd7, 4'd7, 4'd7}; settle();
    chk("R10 unused load source", int'(hold_decode), 0);
    @(negedge clk); dec_use = 3'b111; dec_valid = 1'b0; settle();
    chk("R10 invalid decode", int'(hold_decode), 0);
    to_next_cycle();
    chk("R10 invalid sel", int'(ex_fwd_sel), 0);
  endtask

  task automatic t_pc();
    @(negedge clk); idle();
    set_dec(4'd15, 4'd3, 4'd3, 3'b011);
    ex_rd = 4'd15; ex_wen = 1'b1; ex_load = 1'b1;
    buf_rd = 4'd3; buf_wen = 1'b0;
    settle();
    chk("R8 no stall on pc", int'(hold_decode), 0);
    to_next_cycle();
    chk("R8 pc select", sel_of(0), 4);
    chk("R10 disabled writer", sel_of(1), 0);
  endtask

  task automatic t_multi_load();
    @(negedge clk); idle();
    set_dec(4'd8, 4'd2, 4'd2, 3'b001);
    lm_busy = 1'b1; lm_top_rd = 4'd9;
    settle();
    chk("R9 other register free", int'(hold_decode), 0);
    @(negedge clk); dec_src[3:0] = 4'd9; settle();
    chk("R9 busy hold 1", int'(hold_decode), 1);
    @(negedge clk); settle();
    chk("R9 busy hold 2", int'(hold_decode), 1);
    @(negedge clk); lm_busy = 1'b0; lm_top_rd = 4'd2; settle();
    chk("R9 extra interlock", int'(hold_decode), 1);
    @(negedge clk); settle();
    chk("R9 released", int'(hold_decode), 0);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_three_sources();
    t_priority();
    t_load_use();
    t_load_no_use();
    t_pc();
    t_multi_load();
    @(negedge clk); idle();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule